// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block puts two or three independent down-counting timer channels behind one small register window that is accessed a byte address at a time. Each access is decoded either into a register shared by the whole unit or into one register of the selected channel. A shared start register turns each channel's counting on and off separately, and an optional one-bit output-control register sits at the lowest address. A third channel, the only one able to latch its count on an external capture strobe, is included by a parameter.

Each channel counts down from a loaded value, using a prescaled internal clock or edges of an external timing input. When it runs past zero it reloads from its constant register and raises an underflow flag. Each channel drives one interrupt line. A bad access does not stall the bus: it returns zero and raises a one-cycle error strobe.

Top module: `tmu_unit`

## Requirements
- R1: Read data and the error strobe are registered and appear in the cycle after the access. Byte address 0x04 is the start register. Channel windows begin at 0x08 (channel 0), 0x14 (channel 1) and 0x20 (channel 2). Windows are tested from the highest base down. The register index inside a window is (address − base) >> 2: 0 reload value, 1 count, 2 control, 3 capture (channel 2 only).
- R2: An access to an unmapped address returns 0 and pulses `err_o` for one cycle, and a write there changes nothing. The unmapped addresses are 0x01–0x03, 0x05–0x07, 0x00 without the output-control register, 0x30 and above, and anything at or above 0x20 without the third channel.
- R3: Start bit i runs channel i. The start register reads back the last value accepted. Without the third channel, a write that sets bit 2 pulses `err_o` and is dropped.
- R4: Clearing a start bit freezes that channel's count and prescaler phase, and setting it again resumes from there. Rewriting a start bit with its current value has no effect.
- R5: Control bits [2:0] = 0..4 divide the clock by 4, 16, 64, 256 and 1024. A running channel decrements once per full divider period, counted from its last control write.
- R6: A tick at count 0 loads the reload value and sets control bit 8. Channel interrupt = bit 8 AND control bit 5.
- R7: A control write with bit 8 (or bit 9) at 0 clears that flag. A 1 leaves it unchanged.
- R8: A control write is rejected, with an `err_o` pulse and no change, if bits [2:0] = 5, or if bits [2:0] = 6 or 7 or bits [4:3] ≠ 0 without the external-clock feature, or if bits [7:6] = 1, or if bits [7:6] ≠ 0 on channel 0 or 1.
- R9: With bits [2:0] = 6 or 7, a running channel ticks on `ext_clk_i` edges: bits [4:3] = 0 rising, 1 falling, 2 or 3 both.
- R10: On channel 2 with control bits [7:6] = 2 or 3, a `capture_i` pulse copies the count into the capture register and sets bit 9. Mode 3 also drives the interrupt from bit 9. The capture register is also writable.
- R11: The output-control register stores only write-data bit 0, drives `outctl_o`, and reads back with all other bits 0.
- R12: After reset: start 0, output control 0, counts and reload values all ones, control 0, capture 0, interrupts and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en_i | input | 1 | Read request this cycle |
| wr_en_i | input | 1 | Write request this cycle |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the read |
| err_o | output | 1 | Bad-access strobe, one cycle after the access |
| ext_clk_i | input | 1 | External timing input, synchronous |
| capture_i | input | 1 | Capture strobe for channel 2 |
| outctl_o | output | 1 | Stored output-control bit |
| irq_o | output | 3 or 2 | One interrupt line per channel |

## Verification
Counting is tried with every divider setting and with run lengths just below, at, and just above one divider period and a few periods. A second run after a pause separates a design that keeps its prescaler phase from one that restarts it. Address behaviour is swept over all 256 byte addresses on a three-channel unit and on a reduced unit with no output control. This sweep tells the irregular window bases and highest-first priority apart from an evenly spaced decode. External edges are driven as pulse trains under each edge selection, and a rise-only design gives half the ticks of both-edge mode. Underflow, flag clearing, capture and rejected control values are each tried on the channel they concern.

// File: rtl/tmu_pkg.sv
// Package: shared types, register indices, control field positions and the
// prescaler divider table for the timer unit.
package tmu_pkg;

    // Which register class an access selects.
    typedef enum logic [1:0] {
        SEL_OUTCTL = 2'd0,
        SEL_START  = 2'd1,
        SEL_CHAN   = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    // Decoded access: class, channel number and register index in the window.
    typedef struct packed {
        sel_e       sel;
        logic [1:0] ch;
        logic [1:0] ridx;
    } dec_t;

    // Register indices inside a channel window.
    localparam logic [1:0] RI_RELOAD = 2'd0;
    localparam logic [1:0] RI_COUNT  = 2'd1;
    localparam logic [1:0] RI_CTRL   = 2'd2;
    localparam logic [1:0] RI_CAPT   = 2'd3;

    // Byte addresses of the shared registers and channel window bases.
    localparam int OFS_OUTCTL = 'h00;
    localparam int OFS_START  = 'h04;
    localparam int BASE_CH0   = 'h08;
    localparam int BASE_CH1   = 'h14;
    localparam int BASE_CH2   = 'h20;
    localparam int WIN2_SPAN  = 'h10;

    // Control register field positions.
    localparam int F_PS   = 0;   // prescaler select, 3 bits
    localparam int F_EDGE = 3;   // external edge select, 2 bits
    localparam int F_UIE  = 5;   // underflow interrupt enable
    localparam int F_CAPM = 6;   // capture mode, 2 bits
    localparam int F_UF   = 8;   // underflow flag
    localparam int F_CF   = 9;   // capture flag

    localparam int PRE_W = 10;

    // Terminal prescaler value (divider minus one) for a select code.
    function automatic logic [PRE_W-1:0] div_last(input logic [2:0] code);
        case (code)
            3'd0:    div_last = PRE_W'(3);
            3'd1:    div_last = PRE_W'(15);
            3'd2:    div_last = PRE_W'(63);
            3'd3:    div_last = PRE_W'(255);
            default: div_last = PRE_W'(1023);
        endcase
    endfunction

endpackage

// File: rtl/tmu_addr_dec.sv
// Module: tmu_addr_dec
// Purely combinational decode of a byte address into a shared register, a
// channel register, or nothing. Windows are checked from the highest base
// down, so any address at or above a base belongs to that window.
// Assumes ADDR_W >= 6.
module tmu_addr_dec
    import tmu_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit THREE_CH   = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);

    localparam logic [ADDR_W-1:0] B0    = ADDR_W'(BASE_CH0);
    localparam logic [ADDR_W-1:0] B1    = ADDR_W'(BASE_CH1);
    localparam logic [ADDR_W-1:0] B2    = ADDR_W'(BASE_CH2);
    localparam logic [ADDR_W-1:0] SPAN2 = ADDR_W'(WIN2_SPAN);

    logic [ADDR_W-1:0] off0, off1, off2;

    assign off0 = addr_i - B0;
    assign off1 = addr_i - B1;
    assign off2 = addr_i - B2;

    // Priority decode, highest window first.
    always_comb begin
        dec_o.sel  = SEL_NONE;
        dec_o.ch   = 2'd0;
        dec_o.ridx = 2'd0;
        if (addr_i >= B2) begin
            if (THREE_CH && (off2 < SPAN2)) begin
                dec_o.sel  = SEL_CHAN;
                dec_o.ch   = 2'd2;
                dec_o.ridx = off2[3:2];
            end
        end else if (addr_i >= B1) begin
            dec_o.sel  = SEL_CHAN;
            dec_o.ch   = 2'd1;
            dec_o.ridx = off1[3:2];
        end else if (addr_i >= B0) begin
            dec_o.sel  = SEL_CHAN;
            dec_o.ch   = 2'd0;
            dec_o.ridx = off0[3:2];
        end else if (addr_i == ADDR_W'(OFS_START)) begin
            dec_o.sel = SEL_START;
        end else if (HAS_OUTCTL && (addr_i == ADDR_W'(OFS_OUTCTL))) begin
            dec_o.sel = SEL_OUTCTL;
        end
    end

endmodule

// File: rtl/tmu_tick_gen.sv
// Module: tmu_tick_gen
// Produces the count-enable tick of one channel, either from a prescaler
// counter or from selected edges of the external timing input. The
// prescaler only advances while running and holds its phase when stopped.
// A clear (control write) restarts the phase. Assumes ext_i is synchronous.
module tmu_tick_gen
    import tmu_pkg::*;
#(
    parameter bit HAS_EXT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [2:0] ps_i,
    input  logic [1:0] edge_i,
    input  logic       ext_i,
    output logic       tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic             ext_q;
    logic             ext_mode;
    logic             edge_hit;
    logic             pre_wrap;

    assign ext_mode = HAS_EXT && (ps_i[2:1] == 2'b11);
    assign pre_wrap = (pre_q == div_last(ps_i));

    // Select which transition of the external input counts.
    always_comb begin
        case (edge_i)
            2'd0:    edge_hit = ext_i & ~ext_q;
            2'd1:    edge_hit = ~ext_i & ext_q;
            default: edge_hit = ext_i ^ ext_q;
        endcase
    end

    assign tick_o = run_i && !clr_i && (ext_mode ? edge_hit : pre_wrap);

    // Prescaler phase and external input history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_i;
            if (clr_i) begin
                pre_q <= '0;
            end else if (run_i && !ext_mode) begin
                pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/tmu_chan.sv
// Module: tmu_chan
// One timer channel: reload, count and control registers, plus a capture
// register when HAS_CAPT is set. Checks control writes for reserved values
// and reports them on bad_o (combinational); the write is then dropped.
// Assumes DATA_W >= 10.
module tmu_chan
    import tmu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit HAS_CAPT = 1'b0,
    parameter bit HAS_EXT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_i,
    input  logic [1:0]        ridx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ext_i,
    input  logic              cap_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              bad_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] count_o
);

    logic [DATA_W-1:0] reload_q, count_q, capt_q;
    logic [2:0]        ps_q;
    logic [1:0]        edge_q, capm_q;
    logic              uie_q, uf_q, cf_q;
    logic              we, we_ctrl, tick, ctrl_bad;
    logic [2:0]        w_ps;
    logic [1:0]        w_edge, w_capm;
    logic [DATA_W-1:0] ctrl_v;

    assign w_ps   = wdata_i[F_PS +: 3];
    assign w_edge = wdata_i[F_EDGE +: 2];
    assign w_capm = wdata_i[F_CAPM +: 2];

    // Reserved-value screen for control writes.
    always_comb begin
        ctrl_bad = (w_ps == 3'd5) || (w_capm == 2'd1);
        if (!HAS_EXT && ((w_ps[2:1] == 2'b11) || (w_edge != 2'd0)))
            ctrl_bad = 1'b1;
        if (!HAS_CAPT && (w_capm != 2'd0))
            ctrl_bad = 1'b1;
    end

    assign bad_o   = (ridx_i == RI_CTRL) && ctrl_bad;
    assign we      = wr_i && !bad_o;
    assign we_ctrl = we && (ridx_i == RI_CTRL);

    tmu_tick_gen #(.HAS_EXT(HAS_EXT)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .clr_i  (we_ctrl),
        .ps_i   (ps_q),
        .edge_i (edge_q),
        .ext_i  (ext_i),
        .tick_o (tick)
    );

    // Reload, count, control fields and underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            count_q  <= '1;
            ps_q     <= 3'd0;
            edge_q   <= 2'd0;
            uie_q    <= 1'b0;
            capm_q   <= 2'd0;
            uf_q     <= 1'b0;
        end else begin
            if (we && (ridx_i == RI_RELOAD))
                reload_q <= wdata_i;
            if (we && (ridx_i == RI_COUNT))
                count_q <= wdata_i;
            else if (tick)
                count_q <= (count_q == '0) ? reload_q : count_q - DATA_W'(1);
            if (we_ctrl) begin
                ps_q   <= w_ps;
                edge_q <= w_edge;
                uie_q  <= wdata_i[F_UIE];
                capm_q <= w_capm;
            end
            if (tick && (count_q == '0))
                uf_q <= 1'b1;
            else if (we_ctrl && !wdata_i[F_UF])
                uf_q <= 1'b0;
        end
    end

    generate
        if (HAS_CAPT) begin : g_capt
            logic cap_ev;
            assign cap_ev = cap_i && capm_q[1];
            // Capture register and capture flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    capt_q <= '0;
                    cf_q   <= 1'b0;
                end else begin
                    if (cap_ev)
                        capt_q <= count_q;
                    else if (we && (ridx_i == RI_CAPT))
                        capt_q <= wdata_i;
                    if (cap_ev)
                        cf_q <= 1'b1;
                    else if (we_ctrl && !wdata_i[F_CF])
                        cf_q <= 1'b0;
                end
            end
        end else begin : g_nocapt
            assign capt_q = '0;
            assign cf_q   = 1'b0;
        end
    endgenerate

    // Assemble the control register image.
    always_comb begin
        ctrl_v              = '0;
        ctrl_v[F_PS +: 3]   = ps_q;
        ctrl_v[F_EDGE +: 2] = edge_q;
        ctrl_v[F_UIE]       = uie_q;
        ctrl_v[F_CAPM +: 2] = capm_q;
        ctrl_v[F_UF]        = uf_q;
        ctrl_v[F_CF]        = cf_q;
    end

    // Register read selection.
    always_comb begin
        case (ridx_i)
            RI_RELOAD: rdata_o = reload_q;
            RI_COUNT:  rdata_o = count_q;
            RI_CTRL:   rdata_o = ctrl_v;
            default:   rdata_o = capt_q;
        endcase
    end

    assign irq_o   = (uf_q && uie_q) || (cf_q && (capm_q == 2'd3));
    assign count_o = count_q;

endmodule

// File: rtl/tmu_unit.sv
// Module: tmu_unit (top)
// Timer unit: address decode, shared start and output-control registers,
// and two or three channels. Channel 2 exists only with THREE_CH and is the
// only one with capture. Read data and the error strobe are registered.
// Assumes single-cycle accesses, with rd_en_i and wr_en_i not both set.
module tmu_unit
    import tmu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter bit THREE_CH   = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1,
    parameter bit HAS_EXT    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic                          err_o,
    input  logic                          ext_clk_i,
    input  logic                          capture_i,
    output logic                          outctl_o,
    output logic [(THREE_CH ? 3 : 2)-1:0] irq_o
);

    localparam int NCH = THREE_CH ? 3 : 2;

    dec_t              dec;
    logic [DATA_W-1:0] start_q;
    logic              outctl_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic [DATA_W-1:0] chan_rdata [NCH];
    logic [DATA_W-1:0] cnt_mon    [NCH];
    logic [NCH-1:0]    chan_bad;
    logic [DATA_W-1:0] rd_val;
    logic              sel_bad, start_bad, err_d;

    tmu_addr_dec #(
        .ADDR_W     (ADDR_W),
        .THREE_CH   (THREE_CH),
        .HAS_OUTCTL (HAS_OUTCTL)
    ) u_dec (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            tmu_chan #(
                .DATA_W   (DATA_W),
                .HAS_CAPT (g == 2),
                .HAS_EXT  (HAS_EXT)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .run_i   (start_q[g]),
                .wr_i    (wr_en_i && (dec.sel == SEL_CHAN) && (dec.ch == 2'(g))),
                .ridx_i  (dec.ridx),
                .wdata_i (wdata_i),
                .ext_i   (ext_clk_i),
                .cap_i   (capture_i),
                .rdata_o (chan_rdata[g]),
                .bad_o   (chan_bad[g]),
                .irq_o   (irq_o[g]),
                .count_o (cnt_mon[g])
            );
        end
    endgenerate

    assign start_bad = !THREE_CH && wdata_i[2];

    // Read value and write rejection of the selected register.
    always_comb begin
        rd_val  = '0;
        sel_bad = 1'b0;
        case (dec.sel)
            SEL_OUTCTL: rd_val[0] = outctl_q;
            SEL_START:  rd_val = start_q;
            SEL_CHAN: begin
                for (int i = 0; i < NCH; i++) begin
                    if (dec.ch == 2'(i)) begin
                        rd_val  = chan_rdata[i];
                        sel_bad = chan_bad[i];
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    // Error on unmapped access or rejected write.
    always_comb begin
        err_d = (rd_en_i || wr_en_i) && (dec.sel == SEL_NONE);
        if (wr_en_i && (dec.sel == SEL_START) && start_bad)
            err_d = 1'b1;
        if (wr_en_i && (dec.sel == SEL_CHAN) && sel_bad)
            err_d = 1'b1;
    end

    // Shared registers and registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            outctl_q <= 1'b0;
            rdata_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            if (wr_en_i && (dec.sel == SEL_START) && !start_bad)
                start_q <= wdata_i;
            if (wr_en_i && (dec.sel == SEL_OUTCTL))
                outctl_q <= wdata_i[0];
            rdata_q <= (rd_en_i && (dec.sel != SEL_NONE)) ? rd_val : '0;
            err_q   <= err_d;
        end
    end

    assign rdata_o  = rdata_q;
    assign err_o    = err_q;
    assign outctl_o = outctl_q;

endmodule

// File: rtl/tmu_unit_chk.sv
// Module: tmu_unit_chk
// Property checker bound to tmu_unit. Observes the bus, the start register
// and channel 0's count, using its own model of the address map.
module tmu_unit_chk #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter bit THREE_CH   = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              err_o,
    input logic              outctl_o,
    input logic [DATA_W-1:0] start_q,
    input logic [DATA_W-1:0] cnt0
);

    logic unmapped, ch0_hit;
    int   a;

    // Independent model of which addresses are unmapped.
    always_comb begin
        a        = int'(addr_i);
        unmapped = ((a >= 1) && (a <= 3)) || ((a >= 5) && (a <= 7))
                || ((a == 0) && !HAS_OUTCTL)
                || ((a >= 'h20) && (!THREE_CH || (a >= 'h30)));
        ch0_hit  = (a >= 'h08) && (a < 'h14);
    end

    p_unmapped_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i || wr_en_i) && unmapped |=> err_o && (rdata_o == '0));

    p_idle_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i || wr_en_i) |=> !err_o);

    p_start_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (a == 'h04) && (THREE_CH || !wdata_i[2]) |=> start_q == $past(wdata_i));

    p_stopped_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q[0] && !(wr_en_i && ch0_hit) |=> cnt0 == $past(cnt0));

    p_outctl_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        HAS_OUTCTL && wr_en_i && (a == 'h00) |=> outctl_o == $past(wdata_i[0]));

endmodule

bind tmu_unit tmu_unit_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .THREE_CH   (THREE_CH),
    .HAS_OUTCTL (HAS_OUTCTL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .outctl_o (outctl_o),
    .start_q  (start_q),
    .cnt0     (cnt_mon[0])
);

// File: tb/tmu_unit_test.sv
// Bench for tmu_unit: a full three-channel unit (uut) and a reduced unit
// without third channel or output control (uut2) share address and data.
module tmu_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd1 = 1'b0, wr1 = 1'b0, rd2 = 1'b0, wr2 = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ext_clk = 1'b0, capture = 1'b0;
    logic [31:0] rdata1, rdata2;
    logic        err1, err2, outc1, outc2;
    logic [2:0]  irq1;
    logic [1:0]  irq2;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;
    logic [31:0] q;
    logic        e;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmu_unit uut (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd1), .wr_en_i(wr1),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .err_o(err1),
        .ext_clk_i(ext_clk), .capture_i(capture), .outctl_o(outc1), .irq_o(irq1)
    );

    tmu_unit #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) uut2 (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd2), .wr_en_i(wr2),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata2), .err_o(err2),
        .ext_clk_i(ext_clk), .capture_i(capture), .outctl_o(outc2), .irq_o(irq2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus access, called at a negedge; returns at the next negedge.
    task automatic acc(input bit two, input bit w, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rq, output logic re);
        if (two) begin rd2 = !w; wr2 = w; end
        else     begin rd1 = !w; wr1 = w; end
        addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        rq = two ? rdata2 : rdata1;
        re = two ? err2 : err1;
        rd1 = 1'b0; wr1 = 1'b0; rd2 = 1'b0; wr2 = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] x; logic y;
        acc(1'b0, 1'b1, a, d, x, y);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] x; logic y;
        acc(1'b0, 1'b0, a, '0, x, y);
        check(req, x, exp);
    endtask

    // Run channels in mask for exactly k clock edges (k >= 1).
    task automatic run_for(input logic [31:0] mask, input int k);
        wr(8'h04, mask);
        repeat (k - 1) @(negedge clk);
        wr(8'h04, 32'h0);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; repeat (2) @(negedge clk);
            ext_clk = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    function automatic bit is_bad(input int a, input bit three, input bit outc);
        return ((a >= 1) && (a <= 3)) || ((a >= 5) && (a <= 7)) || ((a == 0) && !outc)
            || ((a >= 'h20) && (!three || (a >= 'h30)));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd_chk("R12 start", 8'h04, 32'h0);
        rd_chk("R12 outctl", 8'h00, 32'h0);
        rd_chk("R12 count", 8'h0C, 32'hFFFF_FFFF);
        rd_chk("R12 reload", 8'h20, 32'hFFFF_FFFF);
        rd_chk("R12 ctrl", 8'h1C, 32'h0);
        rd_chk("R12 capture", 8'h2C, 32'h0);
        check("R12 irq", {29'd0, irq1}, 32'h0);
        check("R12 err", {31'd0, err1}, 32'h0);

        // R2 R1: error pattern over every byte address, both configurations
        for (int a = 0; a < 256; a++) begin
            acc(1'b0, 1'b0, 8'(a), '0, q, e);
            check("R2 err uut", {31'd0, e}, {31'd0, is_bad(a, 1'b1, 1'b1)});
            if (is_bad(a, 1'b1, 1'b1)) check("R2 rdata uut", q, 32'h0);
            acc(1'b1, 1'b0, 8'(a), '0, q, e);
            check("R2 err uut2", {31'd0, e}, {31'd0, is_bad(a, 1'b0, 1'b0)});
        end

        // R1: window bases and register index within a window
        wr(8'h08, 32'hA0); wr(8'h14, 32'hB1); wr(8'h20, 32'hC2);
        rd_chk("R1 ch0 reload", 8'h08, 32'hA0);
        rd_chk("R1 ch1 reload", 8'h14, 32'hB1);
        rd_chk("R1 ch2 reload", 8'h20, 32'hC2);
        rd_chk("R1 byte alias", 8'h0B, 32'hA0);
        wr(8'h2F, 32'h55); rd_chk("R1 ch2 capture idx", 8'h2C, 32'h55);
        wr(8'h13, 32'h20); rd_chk("R1 ch0 ctrl idx", 8'h10, 32'h20);
        wr(8'h10, 32'h0);

        // R2: write to unmapped address has no effect
        wr(8'h04, 32'h0000_0100); wr(8'h00, 32'h0);
        acc(1'b0, 1'b1, 8'h06, 32'hFFFF_FFFF, q, e);
        check("R2 bad write err", {31'd0, e}, 32'h1);
        rd_chk("R2 start untouched", 8'h04, 32'h0000_0100);
        rd_chk("R2 outctl untouched", 8'h00, 32'h0);

        // R3: start readback; bit 2 rejected without third channel
        wr(8'h04, 32'hDEAD_0000); rd_chk("R3 readback", 8'h04, 32'hDEAD_0000);
        wr(8'h04, 32'h0);
        acc(1'b1, 1'b1, 8'h04, 32'h0000_0003, q, e);
        check("R3 uut2 accept", {31'd0, e}, 32'h0);
        acc(1'b1, 1'b1, 8'h04, 32'h0000_0004, q, e);
        check("R3 uut2 bit2 err", {31'd0, e}, 32'h1);
        acc(1'b1, 1'b0, 8'h04, '0, q, e);
        check("R3 uut2 kept", q, 32'h3);
        acc(1'b1, 1'b1, 8'h04, 32'h0, q, e);

        // R5 R4: every divider, run lengths around the period, then resume
        for (int c = 0; c < 5; c++) begin
            int dv;
            dv = 4 << (2 * c);
            for (int j = 0; j < 5; j++) begin
                int k;
                k = (j == 0) ? 1 : (j == 1) ? dv - 1 : (j == 2) ? dv : (j == 3) ? dv + 1 : 3 * dv + 2;
                wr(8'h1C, 32'(c));
                wr(8'h18, 32'd5000);
                run_for(32'h2, k);
                rd_chk("R5 divide", 8'h18, 32'(5000 - k / dv));
                run_for(32'h2, k);
                rd_chk("R4 resume", 8'h18, 32'(5000 - (2 * k) / dv));
            end
        end

        // R4: rewriting the same start bit keeps count and phase (11 edges)
        wr(8'h1C, 32'h0); wr(8'h18, 32'd100);
        wr(8'h04, 32'h2); repeat (5) @(negedge clk);
        wr(8'h04, 32'h2); repeat (4) @(negedge clk);
        wr(8'h04, 32'h0);
        rd_chk("R4 same-value rewrite", 8'h18, 32'd98);

        // R6: underflow reloads, sets bit 8, drives interrupt
        wr(8'h10, 32'h20); wr(8'h08, 32'd5); wr(8'h0C, 32'd2);
        run_for(32'h1, 12);
        rd_chk("R6 reload", 8'h0C, 32'd5);
        rd_chk("R6 flag", 8'h10, 32'h120);
        check("R6 irq", {29'd0, irq1}, 32'h1);

        // R7: flag write semantics
        wr(8'h10, 32'h120);
        rd_chk("R7 keep", 8'h10, 32'h120);
        wr(8'h10, 32'h020);
        rd_chk("R7 clear", 8'h10, 32'h020);
        check("R7 irq low", {29'd0, irq1}, 32'h0);

        // R6: flag without enable gives no interrupt
        wr(8'h10, 32'h0); wr(8'h0C, 32'd0);
        run_for(32'h1, 4);
        rd_chk("R6 flag no enable", 8'h10, 32'h100);
        check("R6 irq masked", {29'd0, irq1}, 32'h0);
        wr(8'h10, 32'h0);

        // R8: reserved control values rejected
        wr(8'h10, 32'h03);
        acc(1'b0, 1'b1, 8'h10, 32'h05, q, e);
        check("R8 ps5 err", {31'd0, e}, 32'h1);
        rd_chk("R8 ps5 kept", 8'h10, 32'h03);
        acc(1'b0, 1'b1, 8'h10, 32'h80, q, e);
        check("R8 capm on ch0 err", {31'd0, e}, 32'h1);
        acc(1'b0, 1'b1, 8'h28, 32'h40, q, e);
        check("R8 capm1 err", {31'd0, e}, 32'h1);
        rd_chk("R8 ch2 ctrl kept", 8'h28, 32'h0);
        acc(1'b1, 1'b1, 8'h10, 32'h08, q, e);
        check("R8 no ext edge err", {31'd0, e}, 32'h0);

        // R9: external edge modes
        wr(8'h10, 32'h06); wr(8'h0C, 32'd100);
        wr(8'h04, 32'h1); ext_pulses(5); wr(8'h04, 32'h0);
        rd_chk("R9 rising", 8'h0C, 32'd95);
        wr(8'h10, 32'h0E); wr(8'h0C, 32'd100);
        wr(8'h04, 32'h1); ext_pulses(5); wr(8'h04, 32'h0);
        rd_chk("R9 falling", 8'h0C, 32'd95);
        wr(8'h10, 32'h17); wr(8'h0C, 32'd100);
        wr(8'h04, 32'h1); ext_pulses(5); wr(8'h04, 32'h0);
        rd_chk("R9 both", 8'h0C, 32'd90);

        // R10: capture on channel 2
        wr(8'h28, 32'hC0); wr(8'h24, 32'h1234);
        capture = 1'b1; @(negedge clk); capture = 1'b0; @(negedge clk);
        rd_chk("R10 captured", 8'h2C, 32'h1234);
        rd_chk("R10 flag", 8'h28, 32'h2C0);
        check("R10 irq", {29'd0, irq1}, 32'h4);
        wr(8'h28, 32'h80);
        check("R10 irq cleared", {29'd0, irq1}, 32'h0);
        wr(8'h24, 32'h77);
        capture = 1'b1; @(negedge clk); capture = 1'b0; @(negedge clk);
        rd_chk("R10 mode2 flag", 8'h28, 32'h280);
        rd_chk("R10 mode2 value", 8'h2C, 32'h77);
        check("R10 mode2 no irq", {29'd0, irq1}, 32'h0);

        // R11: output control stores bit 0 only
        wr(8'h00, 32'hFFFF_FFFF);
        check("R11 pin", {31'd0, outc1}, 32'h1);
        rd_chk("R11 readback", 8'h00, 32'h1);
        wr(8'h00, 32'h2);
        check("R11 pin low", {31'd0, outc1}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule